// File: doc/BRIEF.md
# Low-Power Wakeup Controller

This block governs the two clock-stopped states of a processor subsystem, idle and hold. A one-cycle mode-entry strobe, qualified by a hold-select input, raises a clock-stop request. The request stays high until an enabled wakeup source fires. In hold the block also raises a second output that halts the peripheral clock domain. Idle leaves that domain running.

There are four groups of wakeup sources: four port pins, a watchdog request line, and the real-time clock's second and alarm request lines. Each pin is brought in through a synchronizer that runs on an always-on clock. Only a falling edge on a pin counts as a wake event, and only when its enable bit in a small software-visible register reads zero. When a wakeup happens the block releases clock-stop and pulses a wake event. In the same cycle it pulses exactly one of two outputs: take-interrupt if the global interrupt enable is set, or resume-next-instruction if it is clear. The real-time clock can also be set up to request a system reset. That reset request overrides everything else.

Top module: `lpwake_ctrl`

## Requirements
- R1: After reset the wake-enable register reads 0x0F. A write stores bits 3:0. Bits 7:4 always read as zero.
- R2: Pin n can wake the block only while bit n of the wake-enable register is 0. The pin's falling edge must first be captured at clock edge k. The wake outputs then appear after edge k+2 and not earlier.
- R3: A mode-entry strobe seen while the block is running sets clk_stop one cycle later. hold_sel=1 selects hold, which also sets hold_stop. hold_sel=0 selects idle, which leaves hold_stop low.
- R4: clk_stop stays high until the first enabled wakeup. It falls in the same cycle as the one-cycle wake_evt pulse.
- R5: On each wakeup, exactly one of take_irq and resume_next pulses, in the same cycle as wake_evt. take_irq pulses if gie was 1 in the cycle the request was seen, and resume_next pulses otherwise. With gie clear, take_irq never pulses.
- R6: A pin with its enable bit set does not wake the block. A rising pin edge never wakes the block.
- R7: Wakeup requests that arrive while the block is running produce no wake_evt, take_irq or resume_next. This includes a request in the same cycle as the entry strobe.
- R8: While rtc_rst_en is 0, the watchdog request line, the RTC second line and the RTC alarm line each wake the block. The wake outputs appear one cycle after the request.
- R9: With rtc_rst_en set, an RTC second or alarm request pulses rtc_reset one cycle later, in any state. In a low-power state this also drops clk_stop, with no wake_evt, take_irq or resume_next. In the same cycle as an entry strobe it cancels the entry.
- R10: An entry strobe that arrives while the block is already in a low-power state has no effect. Both clk_stop and hold_stop keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the wake-enable register |
| reg_wdata | input | 8 | Write data for the wake-enable register |
| reg_rdata | output | 8 | Read data of the wake-enable register |
| pin_i | input | 4 | Port pin levels (asynchronous) |
| gie | input | 1 | Global interrupt enable |
| enter_stb | input | 1 | One-cycle low-power entry strobe |
| hold_sel | input | 1 | 1 selects hold, 0 selects idle, on entry |
| wdt_req | input | 1 | Watchdog wakeup request |
| rtc_sec_req | input | 1 | RTC second event |
| rtc_alm_req | input | 1 | RTC alarm event |
| rtc_rst_en | input | 1 | RTC events request reset instead of wakeup |
| clk_stop | output | 1 | Core clock stop request |
| hold_stop | output | 1 | Peripheral clock stop request (hold only) |
| wake_evt | output | 1 | One-cycle wakeup pulse |
| take_irq | output | 1 | Resume through the interrupt service routine |
| resume_next | output | 1 | Resume at the next instruction |
| rtc_reset | output | 1 | One-cycle reset request from the RTC |

## Verification
Two functions can fall in the same cycle: a wakeup request and the entry strobe. The request is ignored because the block is still running. The bench drives a watchdog request together with the strobe. It then expects clk_stop to rise with no wake pulse, and expects the block to stay asleep until a later request arrives. The second overlap is an RTC reset request together with the entry strobe. Here the bench checks that rtc_reset pulses and that clk_stop never rises.

// File: rtl/lpwake_pkg.sv
package lpwake_pkg;

    typedef enum logic [1:0] {
        LP_RUN  = 2'd0,
        LP_IDLE = 2'd1,
        LP_HOLD = 2'd2
    } lp_state_e;

    typedef struct packed {
        lp_state_e st;
        logic      clk_stop;
        logic      wake;
        logic      take;
        logic      resume;
        logic      rst_pulse;
    } lp_regs_t;

endpackage

// File: rtl/lpwake_sync.sv
module lpwake_sync #(
    parameter int NPIN   = 4,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] fall_o
);

    localparam int CHAIN = STAGES + 1;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic [CHAIN-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[CHAIN-2:0], pin_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        // previous synchronized level high, current synchronized level low
        assign fall_o[g] = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];
    end

endmodule

// File: rtl/lpwake_wen_reg.sv
module lpwake_wen_reg #(
    parameter int NPIN  = 4,
    parameter int DW    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic [NPIN-1:0] pin_en
);

    localparam int PAD = DW - NPIN;

    logic [NPIN-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (we) bits_d = wdata[NPIN-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '1;
        else        bits_q <= bits_d;
    end

    assign rdata  = {{PAD{1'b0}}, bits_q};
    assign pin_en = ~bits_q;

endmodule

// File: rtl/lpwake_ctrl.sv
module lpwake_ctrl
    import lpwake_pkg::*;
#(
    parameter int NPIN   = 4,
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NPIN-1:0] pin_i,
    input  logic            gie,
    input  logic            enter_stb,
    input  logic            hold_sel,
    input  logic            wdt_req,
    input  logic            rtc_sec_req,
    input  logic            rtc_alm_req,
    input  logic            rtc_rst_en,
    output logic            clk_stop,
    output logic            hold_stop,
    output logic            wake_evt,
    output logic            take_irq,
    output logic            resume_next,
    output logic            rtc_reset
);

    logic [NPIN-1:0] pin_fall;
    logic [NPIN-1:0] pin_en;
    logic            rtc_evt, rst_req, wake_src;
    lp_regs_t        r_d, r_q;

    lpwake_sync #(.NPIN(NPIN), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .fall_o (pin_fall)
    );

    lpwake_wen_reg #(.NPIN(NPIN), .DW(DW)) u_wen (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .pin_en (pin_en)
    );

    assign rtc_evt  = rtc_sec_req | rtc_alm_req;
    assign rst_req  = rtc_evt & rtc_rst_en;
    assign wake_src = (|(pin_fall & pin_en)) | wdt_req | (rtc_evt & ~rtc_rst_en);

    always_comb begin
        r_d           = r_q;
        r_d.wake      = 1'b0;
        r_d.take      = 1'b0;
        r_d.resume    = 1'b0;
        r_d.rst_pulse = 1'b0;
        if (rst_req) begin
            // reset request overrides entry and wakeup
            r_d.rst_pulse = 1'b1;
            r_d.st        = LP_RUN;
            r_d.clk_stop  = 1'b0;
        end else if (r_q.st == LP_RUN) begin
            if (enter_stb) begin
                r_d.st       = hold_sel ? LP_HOLD : LP_IDLE;
                r_d.clk_stop = 1'b1;
            end
        end else if (wake_src) begin
            r_d.st       = LP_RUN;
            r_d.clk_stop = 1'b0;
            r_d.wake     = 1'b1;
            r_d.take     = gie;
            r_d.resume   = ~gie;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: LP_RUN, default: 1'b0};
        else        r_q <= r_d;
    end

    assign clk_stop    = r_q.clk_stop;
    assign hold_stop   = (r_q.st == LP_HOLD);
    assign wake_evt    = r_q.wake;
    assign take_irq    = r_q.take;
    assign resume_next = r_q.resume;
    assign rtc_reset   = r_q.rst_pulse;

endmodule

// File: rtl/lpwake_ctrl_chk.sv
module lpwake_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_rdata,
    input logic       gie,
    input logic       enter_stb,
    input logic       rtc_rst_en,
    input logic       clk_stop,
    input logic       hold_stop,
    input logic       wake_evt,
    input logic       take_irq,
    input logic       resume_next,
    input logic       rtc_reset
);

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:4] == 4'h0);                                         // R1

    AST_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_stop) |-> $past(enter_stb));                           // R3

    AST_HOLD_IMPLIES_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        hold_stop |-> clk_stop);                                         // R3

    AST_RELEASE_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> ($past(clk_stop) && !clk_stop));                    // R4

    AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_stop) |-> (wake_evt || rtc_reset));                    // R4

    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !wake_evt);                                         // R4

    AST_ONE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> $onehot({take_irq, resume_next}));                  // R5

    AST_NO_STRAY_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq || resume_next) |-> wake_evt);                         // R5

    AST_GIE_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> $past(gie));                                        // R5

    AST_RST_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_reset |-> $past(rtc_rst_en));                                // R9

    AST_RST_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_reset |-> (!wake_evt && !clk_stop));                         // R9

endmodule

bind lpwake_ctrl lpwake_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rdata   (reg_rdata),
    .gie         (gie),
    .enter_stb   (enter_stb),
    .rtc_rst_en  (rtc_rst_en),
    .clk_stop    (clk_stop),
    .hold_stop   (hold_stop),
    .wake_evt    (wake_evt),
    .take_irq    (take_irq),
    .resume_next (resume_next),
    .rtc_reset   (rtc_reset)
);

// File: tb/lpwake_ctrl_bench.sv
`timescale 1ns/1ps
module lpwake_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [3:0] pin_i = 4'hF;
    logic       gie = 1'b0;
    logic       enter_stb = 1'b0;
    logic       hold_sel = 1'b0;
    logic       wdt_req = 1'b0;
    logic       rtc_sec_req = 1'b0;
    logic       rtc_alm_req = 1'b0;
    logic       rtc_rst_en = 1'b0;
    logic       clk_stop, hold_stop, wake_evt, take_irq, resume_next, rtc_reset;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lpwake_ctrl u_lpwake_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pin_i(pin_i), .gie(gie), .enter_stb(enter_stb),
        .hold_sel(hold_sel), .wdt_req(wdt_req), .rtc_sec_req(rtc_sec_req),
        .rtc_alm_req(rtc_alm_req), .rtc_rst_en(rtc_rst_en), .clk_stop(clk_stop),
        .hold_stop(hold_stop), .wake_evt(wake_evt), .take_irq(take_irq),
        .resume_next(resume_next), .rtc_reset(rtc_reset)
    );

    // vector: [15] hold, [14] gie, [13:11] source (0-3 pin, 4 wdt, 5 rtc sec, 6 rtc alarm), [7:0] wake-enable value
    localparam logic [15:0] VEC [8] = '{
        {1'b0, 1'b1, 3'd0, 3'd0, 8'h0E},
        {1'b1, 1'b0, 3'd1, 3'd0, 8'h0D},
        {1'b0, 1'b0, 3'd2, 3'd0, 8'h0B},
        {1'b1, 1'b1, 3'd3, 3'd0, 8'h0F},
        {1'b0, 1'b1, 3'd4, 3'd0, 8'h0F},
        {1'b1, 1'b0, 3'd5, 3'd0, 8'h00},
        {1'b0, 1'b1, 3'd2, 3'd0, 8'h04},
        {1'b1, 1'b1, 3'd6, 3'd0, 8'h0F}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_reg(input logic [7:0] v);
        reg_we = 1'b1; reg_wdata = v;
        step();
        reg_we = 1'b0;
    endtask

    task automatic enter(input logic h);
        enter_stb = 1'b1; hold_sel = h;
        step();
        enter_stb = 1'b0;
    endtask

    task automatic wdt_pulse();
        wdt_req = 1'b1;
        step();
        wdt_req = 1'b0;
    endtask

    task automatic run_vec(input logic [15:0] v);
        logic h, g, exp_w;
        logic [2:0] src;
        logic [7:0] w;
        h = v[15]; g = v[14]; src = v[13:11]; w = v[7:0];
        wr_reg(w);
        gie = g;
        enter(h);
        check("R3 clk_stop", {7'd0, clk_stop}, 8'd1);
        check("R3 hold_stop", {7'd0, hold_stop}, {7'd0, h});
        exp_w = (src < 3'd4) ? ~w[src[1:0]] : 1'b1;
        if (src < 3'd4) begin
            pin_i[src[1:0]] = 1'b0;
            step(); step();
            check("R2 no early wake", {7'd0, wake_evt}, 8'd0);
            step();
        end else begin
            if (src == 3'd4) wdt_req = 1'b1;
            else if (src == 3'd5) rtc_sec_req = 1'b1;
            else rtc_alm_req = 1'b1;
            step();
            wdt_req = 1'b0; rtc_sec_req = 1'b0; rtc_alm_req = 1'b0;
        end
        check(src < 3'd4 ? "R2 pin wake" : "R8 source wake", {7'd0, wake_evt}, {7'd0, exp_w});
        if (exp_w) begin
            check("R4 clk_stop released", {7'd0, clk_stop}, 8'd0);
            check("R5 take_irq", {7'd0, take_irq}, {7'd0, g});
            check("R5 resume_next", {7'd0, resume_next}, {7'd0, ~g});
            step();
            check("R4 single pulse", {7'd0, wake_evt}, 8'd0);
            if (src < 3'd4) pin_i[src[1:0]] = 1'b1;
            repeat (4) step();
        end else begin
            check("R6 disabled pin keeps stop", {7'd0, clk_stop}, 8'd1);
            pin_i[src[1:0]] = 1'b1;
            repeat (4) step();
            check("R6 rising edge no wake", {7'd0, clk_stop}, 8'd1);
            wdt_pulse();
            check("R8 wdt exit", {7'd0, wake_evt}, 8'd1);
            check("R5 take on exit", {7'd0, take_irq}, {7'd0, g});
            step();
        end
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 reset value", reg_rdata, 8'h0F);
        check("R4 clk_stop at reset", {7'd0, clk_stop}, 8'd0);
        check("R5 no resume at reset", {6'd0, take_irq, resume_next}, 8'd0);

        for (int i = 0; i < 8; i++) run_vec(VEC[i]);

        // R1 upper bits read zero
        wr_reg(8'hA5);
        check("R1 masked write", reg_rdata, 8'h05);

        // R7 events while running are ignored
        wr_reg(8'h00);
        gie = 1'b1;
        wdt_pulse();
        check("R7 wdt while running", {6'd0, wake_evt, take_irq}, 8'd0);
        pin_i[0] = 1'b0;
        repeat (3) step();
        check("R7 pin fall while running", {6'd0, wake_evt, clk_stop}, 8'd0);
        pin_i[0] = 1'b1;
        repeat (4) step();

        // R7 request in the entry cycle is ignored
        enter_stb = 1'b1; hold_sel = 1'b0; wdt_req = 1'b1;
        step();
        enter_stb = 1'b0; wdt_req = 1'b0;
        check("R7 entry wins, no wake", {6'd0, wake_evt, clk_stop}, 8'd1);
        step();
        check("R7 still asleep", {7'd0, clk_stop}, 8'd1);

        // R10 second entry while idle has no effect
        enter(1'b1);
        check("R10 hold not taken", {6'd0, hold_stop, clk_stop}, 8'd1);

        // R9 reset request while asleep
        rtc_rst_en = 1'b1; rtc_alm_req = 1'b1;
        step();
        rtc_alm_req = 1'b0;
        check("R9 reset pulse", {7'd0, rtc_reset}, 8'd1);
        check("R9 released without wake", {5'd0, clk_stop, wake_evt, take_irq}, 8'd0);
        step();
        check("R9 pulse ends", {7'd0, rtc_reset}, 8'd0);

        // R9 reset request cancels entry in the same cycle
        enter_stb = 1'b1; hold_sel = 1'b1; rtc_sec_req = 1'b1;
        step();
        enter_stb = 1'b0; rtc_sec_req = 1'b0;
        check("R9 entry cancelled", {5'd0, rtc_reset, clk_stop, hold_stop}, 8'h04);
        rtc_rst_en = 1'b0;

        // R5 gie clear in hold with wdt
        gie = 1'b0;
        enter(1'b1);
        wdt_pulse();
        check("R5 gie clear resumes", {6'd0, take_irq, resume_next}, 8'd1);
        step();

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule